// File: doc/BRIEF.md
# Serial Port Interrupt Identification Unit

This block gathers the interrupt causes of a 16450/16550-style serial port and reports the most urgent enabled one. It produces an identification byte for the host to read and a single interrupt request line. The causes are:

- receive line errors
- received data or a reached FIFO trigger level
- a receive FIFO timeout
- an empty transmit holding register
- modem handshake changes

Each cause is held until the host action that clears it. The sticky causes, the edge-detected transmit-empty cause and the timeout counter are kept here. Data availability is taken as a level from the receive path.

The host reads the identification byte to learn which cause to service. It then performs that cause's clearing action, such as reading the line status or the receive buffer. The value is frozen for as long as an identification read strobe stays high. A transmit-empty cause that is being reported is cleared by the identification read itself. The receive timeout exists only in FIFO mode. It counts character-time ticks while the receive FIFO holds data and nobody touches it.

Top module: `uart_int_ident`

## Requirements
- R1: `irq` is high exactly when some enabled cause is pending, and identification bit 0 is then 0. With nothing pending and enabled, bits 3..0 read 0001, so the idle byte outside FIFO mode is 0x01.
- R2: Identification bits 7 and 6 both equal `fifoMode`. Bits 5 and 4 are always 0. The idle byte in FIFO mode is 0xC1.
- R3: When several causes are pending, bits 3..0 report the highest-priority one, in this order from highest to lowest:
  - line error: 0110
  - data ready: 0100
  - receive timeout: 1100
  - transmit empty: 0010
  - modem change: 0000
- R4: A high level on any bit of `lineErr` (overrun, parity, framing, break) makes the line error cause pending. A one-cycle `rdLine` strobe clears it.
- R5: Outside FIFO mode the data-ready cause follows `rxReady`. In FIFO mode it follows `rxTrig` instead.
- R6: In FIFO mode, with `rxReady` high, the timeout becomes pending on the TO_CHARS-th (default 4) `charTick`. That count is taken since the last `rxPush` or `rdData`, or since data first became present. An `rdData` strobe clears the timeout. Outside FIFO mode the code 1100 never appears, and bit 3 reads 0.
- R7: A rising edge of `txEmpty` makes the transmit-empty cause pending. A `wrData` strobe clears it.
- R8: The first cycle of an `rdIdent` strobe clears the transmit-empty cause only when 0010 is the code being reported in that cycle. Otherwise the cause stays pending.
- R9: A high level on any bit of `modemChg` (CTS change, DSR change, ring trailing edge, DCD change) makes the modem cause pending. A one-cycle `rdModem` strobe clears it.
- R10: `ien` masks reporting without discarding causes: bit 0 covers data ready and timeout, bit 1 transmit empty, bit 2 line error, bit 3 modem. With `ien` all zero, `irq` stays low and the byte is idle.
- R11: While `rdIdent` stays high past its first cycle, `identOut` holds the value it showed in that first cycle, even if causes change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoMode | input | 1 | 1 = FIFO (16550) mode |
| ien | input | 4 | Per-cause enables, map in R10 |
| lineErr | input | 4 | Overrun, parity, framing, break flags |
| rxReady | input | 1 | Receive data present (FIFO non-empty) |
| rxTrig | input | 1 | Receive FIFO at or above trigger level |
| rxPush | input | 1 | A character entered the receive FIFO |
| charTick | input | 1 | One pulse per character time |
| txEmpty | input | 1 | Transmit holding register empty |
| modemChg | input | 4 | CTS, DSR, ring-trailing, DCD change flags |
| rdData | input | 1 | Receive buffer read strobe |
| wrData | input | 1 | Transmit buffer write strobe |
| rdLine | input | 1 | Line status read strobe |
| rdModem | input | 1 | Handshake status read strobe |
| rdIdent | input | 1 | Identification read strobe |
| identOut | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
A strobe or flag that reaches a rising edge updates the stored cause at that edge. `identOut` and `irq` follow combinationally from the stored causes, so results are due one edge after the stimulus. The levels `rxReady`, `rxTrig`, `fifoMode` and `ien` act within the same cycle. The bench drives every input at a falling edge and samples at the next falling edge, after exactly one rising edge. For the identification read it also samples 1 ns after raising the strobe, which is where the first-cycle value is returned. In the timeout scenarios the bench counts ticks one cycle apart, so the fourth tick and not the third produces the code.

// File: rtl/uart_int_pkg.sv
package uart_int_pkg;

  localparam logic [3:0] CODE_NONE  = 4'b0001;
  localparam logic [3:0] CODE_LINE  = 4'b0110;
  localparam logic [3:0] CODE_RX    = 4'b0100;
  localparam logic [3:0] CODE_TOUT  = 4'b1100;
  localparam logic [3:0] CODE_TX    = 4'b0010;
  localparam logic [3:0] CODE_MODEM = 4'b0000;

  typedef struct packed {
    logic clrLine;
    logic clrModem;
    logic clrTout;
    logic clrTx;
    logic tmrRestart;
    logic capture;
    logic useHeld;
  } int_strobe_t;

endpackage

// File: rtl/uart_int_ctrl.sv
module uart_int_ctrl
  import uart_int_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdData,
  input  logic        wrData,
  input  logic        rdLine,
  input  logic        rdModem,
  input  logic        rdIdent,
  input  logic        rxPush,
  input  logic [3:0]  liveCode,
  output int_strobe_t stb
);

  logic rdIdentQ;

  always_ff @(posedge clk) begin
    if (!rstN) rdIdentQ <= 1'b0;
    else       rdIdentQ <= rdIdent;
  end

  always_comb begin
    stb            = '0;
    stb.clrLine    = rdLine;
    stb.clrModem   = rdModem;
    stb.clrTout    = rdData;
    stb.tmrRestart = rdData | rxPush;
    stb.capture    = rdIdent & ~rdIdentQ;
    stb.useHeld    = rdIdent & rdIdentQ;
    stb.clrTx      = wrData | (rdIdent & ~rdIdentQ & (liveCode == CODE_TX));
  end

endmodule

// File: rtl/uart_int_dp.sv
module uart_int_dp
  import uart_int_pkg::*;
#(
  parameter int TO_CHARS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  int_strobe_t stb,
  input  logic        fifoMode,
  input  logic [3:0]  ien,
  input  logic [3:0]  lineErr,
  input  logic        rxReady,
  input  logic        rxTrig,
  input  logic        charTick,
  input  logic        txEmpty,
  input  logic [3:0]  modemChg,
  output logic [3:0]  liveCode,
  output logic [7:0]  identOut,
  output logic        irq
);

  localparam int CNT_W = $clog2(TO_CHARS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TO_CHARS - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(TO_CHARS);

  logic             linePend, modemPend, txPend, txPrev, toutPend;
  logic [CNT_W-1:0] charCnt;
  logic [7:0]       liveIdent, heldIdent;
  logic             toArm, tickDone;
  logic             enLine, enRx, enTout, enTx, enModem;

  assign toArm    = fifoMode & rxReady;
  assign tickDone = charTick & (charCnt == CNT_LAST) & ~stb.tmrRestart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linePend  <= 1'b0;
      modemPend <= 1'b0;
      txPend    <= 1'b0;
      txPrev    <= 1'b0;
      toutPend  <= 1'b0;
      charCnt   <= '0;
      heldIdent <= 8'h01;
    end else begin
      if (|lineErr)         linePend <= 1'b1;
      else if (stb.clrLine) linePend <= 1'b0;

      if (|modemChg)         modemPend <= 1'b1;
      else if (stb.clrModem) modemPend <= 1'b0;

      txPrev <= txEmpty;
      if (txEmpty && !txPrev) txPend <= 1'b1;
      else if (stb.clrTx)     txPend <= 1'b0;

      if (!toArm || stb.tmrRestart)         charCnt <= '0;
      else if (charTick && charCnt != CNT_SAT) charCnt <= charCnt + 1'b1;

      if (!toArm || stb.clrTout) toutPend <= 1'b0;
      else if (tickDone)         toutPend <= 1'b1;

      if (stb.capture) heldIdent <= liveIdent;
    end
  end

  assign enLine  = linePend  & ien[2];
  assign enRx    = (fifoMode ? rxTrig : rxReady) & ien[0];
  assign enTout  = toutPend  & ien[0];
  assign enTx    = txPend    & ien[1];
  assign enModem = modemPend & ien[3];

  always_comb begin
    if (enLine)       liveCode = CODE_LINE;
    else if (enRx)    liveCode = CODE_RX;
    else if (enTout)  liveCode = CODE_TOUT;
    else if (enTx)    liveCode = CODE_TX;
    else if (enModem) liveCode = CODE_MODEM;
    else              liveCode = CODE_NONE;
  end

  assign liveIdent = {fifoMode, fifoMode, 2'b00, liveCode};
  assign identOut  = stb.useHeld ? heldIdent : liveIdent;
  assign irq       = enLine | enRx | enTout | enTx | enModem;

endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
  import uart_int_pkg::*;
#(
  parameter int TO_CHARS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoMode,
  input  logic [3:0] ien,
  input  logic [3:0] lineErr,
  input  logic       rxReady,
  input  logic       rxTrig,
  input  logic       rxPush,
  input  logic       charTick,
  input  logic       txEmpty,
  input  logic [3:0] modemChg,
  input  logic       rdData,
  input  logic       wrData,
  input  logic       rdLine,
  input  logic       rdModem,
  input  logic       rdIdent,
  output logic [7:0] identOut,
  output logic       irq
);

  int_strobe_t stb;
  logic [3:0]  liveCode;

  uart_int_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rdData(rdData), .wrData(wrData),
    .rdLine(rdLine), .rdModem(rdModem), .rdIdent(rdIdent),
    .rxPush(rxPush), .liveCode(liveCode), .stb(stb)
  );

  uart_int_dp #(.TO_CHARS(TO_CHARS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .fifoMode(fifoMode), .ien(ien),
    .lineErr(lineErr), .rxReady(rxReady), .rxTrig(rxTrig),
    .charTick(charTick), .txEmpty(txEmpty), .modemChg(modemChg),
    .liveCode(liveCode), .identOut(identOut), .irq(irq)
  );

endmodule

// File: rtl/uart_int_chk.sv
module uart_int_chk (
  input logic       clk,
  input logic       rstN,
  input logic       fifoMode,
  input logic [3:0] ien,
  input logic [3:0] lineErr,
  input logic [3:0] modemChg,
  input logic       rdIdent,
  input logic [7:0] identOut,
  input logic       irq
);

  assert_irq_matches_bit0_R1: assert property (@(posedge clk) disable iff (!rstN)
    !rdIdent |-> (irq == !identOut[0]));

  assert_high_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rdIdent |-> (identOut[7:6] == {fifoMode, fifoMode} && identOut[5:4] == 2'b00));

  assert_no_timeout_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!rdIdent && !fifoMode) |-> !identOut[3]);

  assert_line_raises_irq_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|lineErr && ien[2]) |=> (!ien[2] || irq));

  assert_modem_raises_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|modemChg && ien[3]) |=> (!ien[3] || irq));

  assert_mask_all_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ien == 4'b0000) |-> !irq);

  assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdent && $past(rdIdent)) |-> $stable(identOut));

endmodule

bind uart_int_ident uart_int_chk u_chk (
  .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .ien(ien), .lineErr(lineErr),
  .modemChg(modemChg), .rdIdent(rdIdent), .identOut(identOut), .irq(irq)
);

// File: tb/uart_int_ident_test.sv
`timescale 1ns/1ps
module uart_int_ident_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fifoMode = 1'b0;
  logic [3:0] ien = 4'h0;
  logic [3:0] lineErr = 4'h0;
  logic       rxReady = 1'b0, rxTrig = 1'b0, rxPush = 1'b0, charTick = 1'b0;
  logic       txEmpty = 1'b0;
  logic [3:0] modemChg = 4'h0;
  logic       rdData = 1'b0, wrData = 1'b0, rdLine = 1'b0, rdModem = 1'b0, rdIdent = 1'b0;
  logic [7:0] identOut;
  logic       irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  uart_int_ident uut (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .ien(ien), .lineErr(lineErr),
    .rxReady(rxReady), .rxTrig(rxTrig), .rxPush(rxPush), .charTick(charTick),
    .txEmpty(txEmpty), .modemChg(modemChg), .rdData(rdData), .wrData(wrData),
    .rdLine(rdLine), .rdModem(rdModem), .rdIdent(rdIdent),
    .identOut(identOut), .irq(irq)
  );

  task automatic chk(string tag, logic [7:0] expId, logic expIrq);
    nChecks++;
    if (identOut !== expId || irq !== expIrq) begin
      nFails++;
      $display("FAIL %s: ident=%02h irq=%b expected ident=%02h irq=%b",
               tag, identOut, irq, expId, expIrq);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulseLine(logic [3:0] v);
    lineErr = v; cyc(); lineErr = 4'h0;
  endtask
  task automatic pulseModem(logic [3:0] v);
    modemChg = v; cyc(); modemChg = 4'h0;
  endtask
  task automatic strobeRdLine();  rdLine = 1'b1;  cyc(); rdLine = 1'b0;  endtask
  task automatic strobeRdModem(); rdModem = 1'b1; cyc(); rdModem = 1'b0; endtask
  task automatic strobeRdData();  rdData = 1'b1;  cyc(); rdData = 1'b0;  endtask
  task automatic strobeWrData();  wrData = 1'b1;  cyc(); wrData = 1'b0;  endtask
  task automatic strobePush();    rxPush = 1'b1;  cyc(); rxPush = 1'b0;  endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin charTick = 1'b1; cyc(); charTick = 1'b0; cyc(); end
  endtask

  task automatic t_reset();
    chk("R1 reset idle", 8'h01, 1'b0);
    fifoMode = 1'b1; cyc();
    chk("R2 fifo idle", 8'hC1, 1'b0);
    fifoMode = 1'b0; cyc();
    chk("R2 back to 16450", 8'h01, 1'b0);
  endtask

  task automatic t_line();
    ien = 4'b0100;
    for (int k = 0; k < 4; k++) begin
      pulseLine(4'h1 << k);
      chk($sformatf("R4 line err bit %0d", k), 8'h06, 1'b1);
      strobeRdLine();
      chk("R4 line cleared", 8'h01, 1'b0);
    end
    ien = 4'h0;
  endtask

  task automatic t_rx();
    ien = 4'b0001;
    rxTrig = 1'b1; cyc();
    chk("R5 trig ignored in 16450", 8'h01, 1'b0);
    rxReady = 1'b1; cyc();
    chk("R5 ready 16450", 8'h04, 1'b1);
    rxTrig = 1'b0; fifoMode = 1'b1; cyc();
    chk("R5 fifo below trig", 8'hC1, 1'b0);
    rxTrig = 1'b1; cyc();
    chk("R5 fifo trig", 8'hC4, 1'b1);
    rxTrig = 1'b0; rxReady = 1'b0; fifoMode = 1'b0; ien = 4'h0; cyc();
  endtask

  task automatic t_timeout();
    ien = 4'b0001; fifoMode = 1'b1; rxReady = 1'b1; cyc();
    ticks(3);
    chk("R6 three ticks", 8'hC1, 1'b0);
    ticks(1);
    chk("R6 fourth tick", 8'hCC, 1'b1);
    strobeRdData();
    chk("R6 cleared by read", 8'hC1, 1'b0);
    ticks(3);
    strobePush();
    ticks(3);
    chk("R6 push restarts", 8'hC1, 1'b0);
    ticks(1);
    chk("R6 timeout after push", 8'hCC, 1'b1);
    rxTrig = 1'b1; cyc();
    chk("R3 data ready over timeout", 8'hC4, 1'b1);
    rxTrig = 1'b0; strobeRdData();
    fifoMode = 1'b0; cyc();
    ticks(6);
    chk("R6 no timeout in 16450", 8'h04, 1'b1);
    rxReady = 1'b0; ien = 4'h0; cyc();
  endtask

  task automatic t_tx();
    ien = 4'b0010;
    txEmpty = 1'b1; cyc();
    chk("R7 tx empty rise", 8'h02, 1'b1);
    strobeWrData();
    chk("R7 cleared by write", 8'h01, 1'b0);
    txEmpty = 1'b0; cyc(); txEmpty = 1'b1; cyc();
    chk("R7 second rise", 8'h02, 1'b1);
    rdIdent = 1'b1; #1;
    chk("R8 read returns tx code", 8'h02, 1'b1);
    cyc(); rdIdent = 1'b0; #1;
    chk("R8 tx cleared by ident read", 8'h01, 1'b0);
    txEmpty = 1'b0; cyc(); txEmpty = 1'b1; cyc();
    ien = 4'b0110; pulseLine(4'h2);
    rdIdent = 1'b1; #1;
    chk("R8 read returns line code", 8'h06, 1'b1);
    cyc(); rdIdent = 1'b0; #1;
    strobeRdLine();
    chk("R8 tx kept when not reported", 8'h02, 1'b1);
    strobeWrData();
    txEmpty = 1'b0; ien = 4'h0; cyc();
  endtask

  task automatic t_modem();
    ien = 4'b1000;
    for (int k = 0; k < 4; k++) begin
      pulseModem(4'h1 << k);
      chk($sformatf("R9 modem bit %0d", k), 8'h00, 1'b1);
      strobeRdModem();
      chk("R9 modem cleared", 8'h01, 1'b0);
    end
    ien = 4'h0;
  endtask

  task automatic t_priority();
    ien = 4'hF;
    pulseModem(4'h4);
    chk("R3 modem alone", 8'h00, 1'b1);
    txEmpty = 1'b1; cyc();
    chk("R3 tx over modem", 8'h02, 1'b1);
    rxReady = 1'b1; cyc();
    chk("R3 rx over tx", 8'h04, 1'b1);
    pulseLine(4'h8);
    chk("R3 line highest", 8'h06, 1'b1);
    strobeRdLine();
    chk("R3 line gone", 8'h04, 1'b1);
    rxReady = 1'b0; cyc();
    chk("R3 rx gone", 8'h02, 1'b1);
    strobeWrData();
    chk("R3 tx gone", 8'h00, 1'b1);
    strobeRdModem();
    chk("R3 all gone", 8'h01, 1'b0);
    txEmpty = 1'b0; ien = 4'h0; cyc();
  endtask

  task automatic t_enables();
    ien = 4'h0;
    pulseLine(4'h1); pulseModem(4'h1);
    chk("R10 all masked", 8'h01, 1'b0);
    ien = 4'b1000; cyc();
    chk("R10 modem unmasked", 8'h00, 1'b1);
    ien = 4'b1100; cyc();
    chk("R10 line unmasked", 8'h06, 1'b1);
    strobeRdLine(); strobeRdModem();
    chk("R10 cleared", 8'h01, 1'b0);
    ien = 4'h0; cyc();
  endtask

  task automatic t_hold();
    ien = 4'b0100;
    rdIdent = 1'b1; #1;
    chk("R11 first read cycle", 8'h01, 1'b0);
    cyc(); lineErr = 4'h1; cyc(); lineErr = 4'h0; cyc(); #1;
    chk("R11 held during read", 8'h01, 1'b1);
    rdIdent = 1'b0; #1;
    chk("R11 live after read", 8'h06, 1'b1);
    strobeRdLine();
    ien = 4'h0; cyc();
  endtask

  initial begin
    repeat (4) cyc();
    rstN = 1'b1; cyc();
    t_reset();
    t_line();
    t_rx();
    t_timeout();
    t_tx();
    t_modem();
    t_priority();
    t_enables();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule